// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of a single DMA channel: a current memory address, a current byte count, and a saved base copy of each. Software programs the channel by writing an address and a count. Each write loads the base copy and the working copy in the same cycle, and either write arms the channel. Each accepted transfer strobe moves the address one step up or down and uses up one count.

The loaded count is one less than the number of bytes to move. A strobe that arrives while the count is zero is the last byte. That strobe raises terminal count during its own cycle, produces a one-cycle end-of-process pulse on the following cycle, and sets a sticky status flag that clears when status is read.

After terminal count the channel does one of two things. With automatic re-arming selected, it copies the base address and count back into the working registers and keeps accepting strobes. Otherwise it stops and ignores strobes until it is written again. The working address is driven out to the bus side. Arbitration and bus timing belong to other blocks.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, cur_addr is 0, eop and tc_status are 0, and the channel is idle: transfer strobes are ignored until an address or count write arrives.
- R2: A write with prog_addr_wr loads prog_data into both the base and the working address, and cur_addr shows the value from the next cycle on. A write with prog_cnt_wr loads the base and working count the same way. Either write re-arms a stopped channel.
- R3: An accepted strobe with mode_dec=0 adds one to cur_addr, and with mode_dec=1 subtracts one. The change shows on the next cycle and wraps modulo 2^ADDR_W.
- R4: After a count N is loaded, the (N+1)th accepted strobe is the terminal one, so a count of 0 moves a single byte. tc is high, combinationally, only during the cycle of that strobe.
- R5: eop is high for exactly one cycle, the cycle after the terminal strobe.
- R6: tc_status goes to 1 on the cycle after a terminal strobe and stays 1 until a cycle with stat_rd=1. If a terminal strobe and stat_rd fall in the same cycle, the flag ends up set.
- R7: With mode_auto=0, the terminal strobe still moves the address one step. After that, strobes leave cur_addr unchanged and raise no tc until the next programming write.
- R8: With mode_auto=1, the cycle after the terminal strobe shows the base address on cur_addr, the base count is back in force, and strobes continue to be accepted.
- R9: A programming write takes priority over a strobe in the same cycle. That strobe is not counted and does not move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_addr_wr | input | 1 | Load base and working address from prog_data |
| prog_cnt_wr | input | 1 | Load base and working count from prog_data |
| prog_data | input | DATA_W (16) | Programming value |
| mode_dec | input | 1 | 1 = address steps down, 0 = up |
| mode_auto | input | 1 | 1 = re-arm from base registers at terminal count |
| xfer | input | 1 | One byte transferred this cycle |
| stat_rd | input | 1 | Status read; clears tc_status |
| cur_addr | output | ADDR_W (16) | Working address for the bus side |
| tc | output | 1 | Terminal count, during the last strobe |
| eop | output | 1 | End-of-process pulse, one cycle |
| tc_status | output | 1 | Sticky terminal-count flag |

## Verification
A count register that is off by one, or that reloads the wrong value, does not show up on the address. It shows up as tc arriving one strobe too early or too late. The bench therefore compares tc in every strobe cycle, not only at the end of a run. A stop flag that is wrong appears on the first ignored strobe after terminal count, as a moving cur_addr or a repeated tc. A bad reload appears on the very next cycle as a cur_addr that differs from the programmed base. Because the model is compared on every clock, each of these faults is reported within one cycle of the first port that differs.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
   typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} step_dir_e;

   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
   import dma_eng_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         reload,
   input  logic         step,
   input  step_dir_e    dir,
   output logic [W-1:0] cur,
   output logic [W-1:0] base
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         cur  <= '0;
      end else if (load) begin
         base <= load_val;
         cur  <= load_val;
      end else if (reload) begin
         cur <= base;
      end else if (step) begin
         cur <= (dir == DIR_DOWN) ? cur - ONE : cur + ONE;
      end
   end

   // R2: a load is visible on the working register next cycle
   assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cur == $past(load_val));
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         reload,
   input  logic         step,
   output logic         at_zero
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] base_q;
   logic [W-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= load_val;
         cur_q  <= load_val;
      end else if (reload) begin
         cur_q <= base_q;
      end else if (step) begin
         cur_q <= cur_q - ONE;
      end
   end

   assign at_zero = (cur_q == '0);
endmodule

// File: rtl/dma_tc_ctrl.sv
module dma_tc_ctrl #(
   parameter bit AUTO_INIT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer,
   input  logic any_wr,
   input  logic cnt_zero,
   input  logic auto_mode,
   input  logic stat_rd,
   output logic accept,
   output logic tc,
   output logic reload,
   output logic stopped,
   output logic eop,
   output logic tc_status
);
   logic auto_eff;

   generate
      if (AUTO_INIT_EN) begin : g_auto
         assign auto_eff = auto_mode;
      end else begin : g_noauto
         logic unused_auto;
         assign unused_auto = auto_mode;
         assign auto_eff    = 1'b0;
      end
   endgenerate

   assign accept = xfer && !stopped && !any_wr;
   assign tc     = accept && cnt_zero;
   assign reload = tc && auto_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped   <= 1'b1;
         eop       <= 1'b0;
         tc_status <= 1'b0;
      end else begin
         eop       <= tc;
         tc_status <= tc || (tc_status && !stat_rd);
         if (any_wr)
            stopped <= 1'b0;
         else if (tc && !auto_eff)
            stopped <= 1'b1;
      end
   end

   assert_eop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eop |=> !eop);
   assert_eop_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> eop);
   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tc_status && !stat_rd |=> tc_status);
   assert_tc_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> xfer);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_eng_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned CNT_W        = 16,
   parameter bit          AUTO_INIT_EN = 1'b1,
   localparam int unsigned DATA_W      = max_w(ADDR_W, CNT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_addr_wr,
   input  logic              prog_cnt_wr,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              mode_dec,
   input  logic              mode_auto,
   input  logic              xfer,
   input  logic              stat_rd,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              tc,
   output logic              eop,
   output logic              tc_status
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("dma_chan_engine: ADDR_W must lie in 2..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("dma_chan_engine: CNT_W must lie in 1..32");
      end
   endgenerate

   logic              accept, reload, stopped, cnt_zero, any_wr;
   logic [ADDR_W-1:0] base_addr;
   step_dir_e         dir;

   assign any_wr = prog_addr_wr || prog_cnt_wr;
   assign dir    = step_dir_e'(mode_dec);

   dma_addr_unit #(.W(ADDR_W)) u_addr (
      .clk, .rst_n,
      .load     (prog_addr_wr),
      .load_val (prog_data[ADDR_W-1:0]),
      .reload   (reload),
      .step     (accept),
      .dir      (dir),
      .cur      (cur_addr),
      .base     (base_addr)
   );

   dma_count_unit #(.W(CNT_W)) u_cnt (
      .clk, .rst_n,
      .load     (prog_cnt_wr),
      .load_val (prog_data[CNT_W-1:0]),
      .reload   (reload),
      .step     (accept),
      .at_zero  (cnt_zero)
   );

   dma_tc_ctrl #(.AUTO_INIT_EN(AUTO_INIT_EN)) u_ctl (
      .clk, .rst_n,
      .xfer, .any_wr,
      .cnt_zero,
      .auto_mode (mode_auto),
      .stat_rd,
      .accept, .tc, .reload, .stopped, .eop, .tc_status
   );

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !reload && dir == DIR_UP |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !reload && dir == DIR_DOWN |=> cur_addr == $past(cur_addr) - ADDR_W'(1));
   assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && !any_wr |=> $stable(cur_addr));
   assert_reload_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> cur_addr == $past(base_addr));
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && any_wr |-> !tc);
endmodule

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aw = 0, cw = 0, dec = 0, auto_m = 0, x = 0, rd = 0;
   logic [15:0] d = '0;
   logic [15:0] cur_addr;
   logic        tc, eop, tc_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model state
   logic [15:0] m_addr = 0, m_cnt = 0, m_ba = 0, m_bc = 0;
   bit m_stop = 1, m_stat = 0, m_eop = 0;

   always #2 clk = ~clk;

   dma_chan_engine u0 (
      .clk, .rst_n,
      .prog_addr_wr(aw), .prog_cnt_wr(cw), .prog_data(d),
      .mode_dec(dec), .mode_auto(auto_m), .xfer(x), .stat_rd(rd),
      .cur_addr, .tc, .eop, .tc_status
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clock: check registered outputs, drive inputs, check tc, advance model
   task automatic cyc(input string req, input bit a_wr, input bit c_wr, input logic [15:0] val,
                      input bit dn, input bit au, input bit xf, input bit rdd);
      bit acc, tce;
      @(negedge clk);
      chk(req, "cur_addr", int'(cur_addr), int'(m_addr));
      chk(req, "eop", int'(eop), int'(m_eop));
      chk(req, "tc_status", int'(tc_status), int'(m_stat));
      aw = a_wr; cw = c_wr; d = val; dec = dn; auto_m = au; x = xf; rd = rdd;
      acc = xf && !m_stop && !a_wr && !c_wr;
      tce = acc && (m_cnt == 0);
      #1;
      chk(req, "tc", int'(tc), int'(tce));
      m_stat = tce || (m_stat && !rdd);
      m_eop  = tce;
      if (a_wr) begin m_ba = val; m_addr = val; m_stop = 0; end
      if (c_wr) begin m_bc = val; m_cnt = val; m_stop = 0; end
      if (acc) begin
         if (tce && au) begin
            m_addr = m_ba; m_cnt = m_bc;
         end else begin
            m_addr = dn ? m_addr - 16'd1 : m_addr + 16'd1;
            m_cnt  = m_cnt - 16'd1;
            if (tce) m_stop = 1;
         end
      end
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, dec, auto_m, 0, 0);
   endtask

   initial begin
      #9 rst_n = 1'b1;
      // R1: reset values and idle channel ignoring strobes
      cyc("R1", 0, 0, 0, 0, 0, 1, 0);
      cyc("R1", 0, 0, 0, 0, 0, 1, 0);
      // R2: program address then count
      cyc("R2", 1, 0, 16'h1000, 0, 0, 0, 0);
      cyc("R2", 0, 1, 16'd2, 0, 0, 0, 0);
      // R3/R4: three strobes up, tc on third, with a gap
      cyc("R3", 0, 0, 0, 0, 0, 1, 0);
      cyc("R3", 0, 0, 0, 0, 0, 0, 0);
      cyc("R3", 0, 0, 0, 0, 0, 1, 0);
      cyc("R4", 0, 0, 0, 0, 0, 1, 0);
      // R5/R7: eop pulse, then ignored strobes
      for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 0, 0, 0, 1, 0);
      // R6: status sticky then cleared by read
      idle("R6", 2);
      cyc("R6", 0, 0, 0, 0, 0, 0, 1);
      idle("R6", 1);
      // R3 down with wrap: address 1, count 3
      cyc("R2", 1, 1, 16'h0001, 1, 0, 0, 0);
      cyc("R2", 0, 1, 16'd3, 1, 0, 0, 0);
      for (int i = 0; i < 6; i++) cyc("R3", 0, 0, 0, 1, 0, 1, 0);
      // R4: count 0 moves one byte
      cyc("R4", 1, 0, 16'h0050, 0, 0, 0, 0);
      cyc("R4", 0, 1, 16'd0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R4", 0, 0, 0, 0, 0, 1, 0);
      // R8: auto re-arm, base 0x2000 count 1, run three blocks
      cyc("R8", 1, 1, 16'h2000, 0, 1, 0, 0);
      cyc("R8", 0, 1, 16'd1, 0, 1, 0, 0);
      for (int i = 0; i < 7; i++) cyc("R8", 0, 0, 0, 0, 1, 1, 0);
      // R6: tc and read in the same cycle leaves flag set
      cyc("R6", 0, 0, 0, 0, 1, 1, 1);
      cyc("R6", 0, 0, 0, 0, 1, 1, 1);
      idle("R6", 2);
      // R9: write with strobe in same cycle
      cyc("R9", 1, 0, 16'h3000, 0, 0, 1, 1);
      cyc("R9", 0, 1, 16'd1, 0, 0, 1, 0);
      cyc("R9", 0, 0, 0, 0, 0, 1, 0);
      cyc("R9", 0, 0, 0, 0, 0, 1, 0);
      cyc("R9", 0, 0, 0, 0, 0, 1, 0);
      // R8 in down direction
      cyc("R8", 1, 1, 16'h0002, 1, 1, 0, 0);
      for (int i = 0; i < 8; i++) cyc("R8", 0, 0, 0, 1, 1, 1, 0);
      idle("R5", 2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule